// File: doc/BRIEF.md
# Multichannel Complex Digital Downconverter

This block takes real 12-bit sample streams from several channels that share one sample clock. All channels are mixed against a single shared quadrature oscillator, so a test tone placed anywhere inside one Nyquist zone can be moved to or near 0 Hz. Each channel's complex product is then passed through a three-stage cascaded integrator-comb low-pass filter and decimated by a programmable ratio. The result is a narrow complex baseband stream per channel, which can be as short as one complex value per measurement.

Every channel sees exactly the same oscillator phase sequence, and that sequence is restarted by a single start strobe. Any phase difference between two channel outputs therefore comes only from the analog path ahead of the block. A downstream phase estimator forms conjugate products of the channel outputs. That estimator, the converters and the capture memory are outside this block.

Top module: `mc_ddc`

## Requirements
- R1: The oscillator phase is a 32-bit accumulator. It is zero after reset and after a start strobe, and it advances by the latched tuning word once per accepted sample. Each sample is mixed with the phase value held before its own advance. The lookup index p is the top 8 phase bits. The oscillator values are cos = round(2047·cos(2πp/256)) and sin = round(2047·sin(2πp/256)), where round takes the nearest integer with halves away from zero.
- R2: Each mixed value is 16 bits, computed as floor((x·L + 64) / 128) with x the signed 12-bit sample. For I, L is the cosine value. For Q, L is the negated sine value.
- R3: All channels use the same oscillator value in the same cycle, so identical inputs on every channel give identical outputs on every channel.
- R4: Each component output equals the sum over i = 0 … 3R−3 of h[i]·m[j−i], where h is the convolution of three length-R all-ones windows, m is the mixed stream counted from the start strobe and j is the latest accepted sample. The sum is shifted right arithmetically by 22 bits and its low 24 bits are kept.
- R5: The output valid flag pulses for one cycle at every R-th accepted sample. The first two pulses after a start are suppressed, so the first output belongs to accepted sample 3R. With uninterrupted input, successive pulses are exactly R cycles apart.
- R6: The ratio input is clamped to the range 8 to 1024: values below 8 act as 8 and values above 1024 act as 1024.
- R7: The tuning word and the ratio are captured only on a start strobe. Changing them between strobes has no effect on the outputs.
- R8: A start strobe clears all filter state and the output registers. A sample presented in the same cycle as the strobe is discarded. In the cycle after a strobe, the valid flag is low and both outputs are zero.
- R9: In a cycle with the input valid flag low, the sample data is ignored and the oscillator does not advance. Gaps in the input therefore leave the outputs unchanged.
- R10: After reset the valid flag is low and both outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe: restarts the oscillator and clears the filters |
| tune | input | 32 | Oscillator phase increment per accepted sample |
| ratio | input | 11 | Decimation ratio R, captured on start |
| in_valid | input | 1 | A sample is present on every channel |
| in_data | input | NCH·12 | Signed samples, channel k at bits [12k+11:12k] |
| out_valid | output | 1 | One-cycle pulse when new outputs are present |
| out_i | output | NCH·24 | In-phase outputs, channel k at bits [24k+23:24k] |
| out_q | output | NCH·24 | Quadrature outputs, same layout as out_i |

## Verification
A phase accumulator that is wrong or advances out of step shows as a mismatch in the complex output values at the very next valid pulse. Once the three-window history has filled, every later output of that run is also wrong. A miscounted decimation counter or fill stage moves the valid pulses, so the number of outputs per run and the spacing between pulses no longer match R. This is visible within one output period. Corrupted integrator or comb state, or a leftover from a previous run that survives the start strobe, gives output values that differ from the convolution model, and this shows at the first output of the run.

// File: rtl/mc_ddc.sv
module mc_ddc #(
  parameter int NCH  = 4,
  parameter int DW   = 12,
  parameter int PW   = 32,
  parameter int LW   = 12,
  parameter int AW   = 8,
  parameter int MW   = 16,
  parameter int OW   = 24,
  parameter int RMIN = 8,
  parameter int RMAX = 1024
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [PW-1:0]           tune,
  input  logic [$clog2(RMAX):0]   ratio,
  input  logic                    in_valid,
  input  logic [NCH*DW-1:0]       in_data,
  output logic                    out_valid,
  output logic [NCH*OW-1:0]       out_i,
  output logic [NCH*OW-1:0]       out_q
);
  localparam int RW  = $clog2(RMAX) + 1;
  localparam int IW  = MW + 3 * $clog2(RMAX);
  localparam int QN  = 1 << (AW - 2);
  localparam int SH  = DW + LW - 1 - MW;
  localparam int PRW = DW + LW;

  logic [PW-1:0] acc, tune_q;
  logic [RW-1:0] r_q, cnt, r_cl;
  logic [1:0]    fill;
  logic          mv;

  assign r_cl = (ratio < RW'(RMIN)) ? RW'(RMIN) :
                (ratio > RW'(RMAX)) ? RW'(RMAX) : ratio;

  logic [LW-2:0] qrom [0:QN];
  for (genvar k = 0; k <= QN; k++) begin : g_rom
    assign qrom[k] = (LW-1)'($rtoi(real'((1 << (LW-1)) - 1)
                     * $sin(3.14159265358979 * real'(k) / (2.0 * real'(QN))) + 0.5));
  end

  logic [AW-1:0] ps, pc;
  logic [AW-2:0] is, ic;
  logic signed [LW-1:0] mag_s, mag_c, lo_c, lo_ns;

  assign ps    = acc[PW-1 -: AW];
  assign pc    = ps + AW'(QN);
  assign is    = ps[AW-2] ? (AW-1)'(QN) - {1'b0, ps[AW-3:0]} : {1'b0, ps[AW-3:0]};
  assign ic    = pc[AW-2] ? (AW-1)'(QN) - {1'b0, pc[AW-3:0]} : {1'b0, pc[AW-3:0]};
  assign mag_s = $signed({1'b0, qrom[is]});
  assign mag_c = $signed({1'b0, qrom[ic]});
  assign lo_c  = pc[AW-1] ? -mag_c : mag_c;
  assign lo_ns = ps[AW-1] ? mag_s : -mag_s;

  wire adv  = mv & ~start;
  wire tick = adv && (cnt == r_q - RW'(1));
  wire emit = tick && (fill == 2'd2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0; tune_q <= '0; r_q <= RW'(RMIN);
      mv <= 1'b0; cnt <= '0; fill <= '0; out_valid <= 1'b0;
    end else if (start) begin
      acc <= '0; tune_q <= tune; r_q <= r_cl;
      mv <= 1'b0; cnt <= '0; fill <= '0; out_valid <= 1'b0;
    end else begin
      mv <= in_valid;
      out_valid <= emit;
      if (in_valid) acc <= acc + tune_q;
      if (adv) begin
        if (tick) begin
          cnt <= '0;
          if (fill != 2'd2) fill <= fill + 2'd1;
        end else begin
          cnt <= cnt + RW'(1);
        end
      end
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic signed [DW-1:0] x;
    assign x = in_data[ch*DW +: DW];

    for (genvar c = 0; c < 2; c++) begin : g_cmp
      logic signed [LW-1:0]  lo;
      logic signed [PRW-1:0] pr, prr, sh;
      logic signed [MW-1:0]  m_r;
      logic signed [IW-1:0]  i1, i2, i3, s1, s2, s3;
      logic signed [IW-1:0]  dl1, dl2, dl3, d1, d2, d3;
      logic [OW-1:0]         yo;

      assign lo  = (c == 0) ? lo_c : lo_ns;
      assign pr  = x * lo;
      assign prr = pr + PRW'(1 << (SH - 1));
      assign sh  = prr >>> SH;

      assign s1 = i1 + IW'(m_r);
      assign s2 = i2 + s1;
      assign s3 = i3 + s2;
      assign d1 = s3 - dl1;
      assign d2 = d1 - dl2;
      assign d3 = d2 - dl3;

      always_ff @(posedge clk) begin
        if (in_valid) m_r <= sh[MW-1:0];
        if (!rst_n || start) begin
          i1 <= '0; i2 <= '0; i3 <= '0;
          dl1 <= '0; dl2 <= '0; dl3 <= '0;
          yo <= '0;
        end else if (adv) begin
          i1 <= s1; i2 <= s2; i3 <= s3;
          if (tick) begin
            dl1 <= s3; dl2 <= d1; dl3 <= d2;
            if (emit) yo <= d3[IW-1 -: OW];
          end
        end
      end

      if (c == 0) begin : g_oi
        assign out_i[ch*OW +: OW] = yo;
      end else begin : g_oq
        assign out_q[ch*OW +: OW] = yo;
      end
    end
  end
endmodule

// File: rtl/mc_ddc_chk.sv
module mc_ddc_chk #(
  parameter int PW   = 32,
  parameter int RW   = 11,
  parameter int NO   = 96,
  parameter int RMIN = 8,
  parameter int RMAX = 1024
)(
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          in_valid,
  input logic          out_valid,
  input logic [NO-1:0] out_i,
  input logic [NO-1:0] out_q,
  input logic [RW-1:0] rq,
  input logic [PW-1:0] phase
);
  a_r1_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (phase == '0));

  a_r9_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !start) |=> $stable(phase));

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  a_r5_needs_sample: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(in_valid, 2) && !$past(start) && !$past(start, 2)));

  a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!out_valid && out_i == '0 && out_q == '0));

  a_r4_output_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (out_valid || ($stable(out_i) && $stable(out_q))));

  a_r6_ratio_range: assert property (@(posedge clk) disable iff (!rst_n)
    (rq >= RW'(RMIN)) && (rq <= RW'(RMAX)));
endmodule

bind mc_ddc mc_ddc_chk #(
  .PW(PW), .RW(RW), .NO(NCH*OW), .RMIN(RMIN), .RMAX(RMAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
  .out_valid(out_valid), .out_i(out_i), .out_q(out_q),
  .rq(r_q), .phase(acc)
);

// File: tb/mc_ddc_tb.sv
`timescale 1ns/1ps
module mc_ddc_tb;
  localparam int NCH = 4, DW = 12, OW = 24;
  localparam real TWO_PI = 6.28318530717959;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, start, in_valid, out_valid;
  logic [31:0] tune;
  logic [10:0] ratio;
  logic [NCH*DW-1:0] in_data;
  logic [NCH*OW-1:0] out_i, out_q;

  mc_ddc #(.NCH(NCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .tune(tune), .ratio(ratio),
    .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  int errors = 0, checks = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  bit [31:0] m_ph, m_tune;
  int m_r, m_n, exp_out, seen, last_cyc;
  bit cont, same;
  longint h[];
  longint hist[NCH][2][$];
  logic [NCH*OW-1:0] qi[$], qq[$];
  logic [NCH*OW-1:0] last_i, last_q;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int rnd(input real v);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(0.5 - v);
  endfunction

  task automatic new_cfg(input logic [31:0] tw, input logic [10:0] rr);
    longint h2[];
    m_ph = 0; m_tune = tw;
    m_r = (rr < 8) ? 8 : ((rr > 1024) ? 1024 : int'(rr));
    h = new[3*m_r-2];
    h2 = new[2*m_r-1];
    for (int a = 0; a < m_r; a++)
      for (int b = 0; b < m_r; b++) h2[a+b]++;
    for (int k = 0; k < 2*m_r-1; k++)
      for (int c = 0; c < m_r; c++) h[k+c] += h2[k];
    for (int ch = 0; ch < NCH; ch++)
      for (int c = 0; c < 2; c++) hist[ch][c].delete();
    m_n = 0; exp_out = 0; seen = 0; last_cyc = -1;
  endtask

  task automatic model_push(input logic [NCH*DW-1:0] d);
    int p, lc, ls;
    logic [NCH*OW-1:0] ei, eq;
    p = int'(m_ph[31:24]);
    lc = rnd(2047.0 * $cos(TWO_PI * p / 256.0));
    ls = rnd(2047.0 * $sin(TWO_PI * p / 256.0));
    for (int ch = 0; ch < NCH; ch++) begin
      longint x;
      x = longint'($signed(d[ch*DW +: DW]));
      hist[ch][0].push_back((x * lc + 64) >>> 7);
      hist[ch][1].push_back((-x * ls + 64) >>> 7);
    end
    m_ph = m_ph + m_tune;
    m_n++;
    if (m_n % m_r == 0 && m_n / m_r >= 3) begin
      for (int ch = 0; ch < NCH; ch++) begin
        for (int c = 0; c < 2; c++) begin
          longint y, ys;
          y = 0;
          for (int i = 0; i <= 3*m_r-3; i++) y += h[i] * hist[ch][c][m_n-1-i];
          ys = y >>> 22;
          if (c == 0) ei[ch*OW +: OW] = ys[OW-1:0];
          else        eq[ch*OW +: OW] = ys[OW-1:0];
        end
      end
      qi.push_back(ei); qq.push_back(eq);
      exp_out++;
    end
  endtask

  function automatic logic [NCH*DW-1:0] gen(input int mode, input int k, input int cval);
    logic [NCH*DW-1:0] d;
    for (int ch = 0; ch < NCH; ch++) begin
      int v;
      case (mode)
        0: v = rnd(1800.0 * $cos(TWO_PI * 0.1023 * k + 0.7 * ch));
        1: v = rnd(1800.0 * $cos(TWO_PI * 0.1871 * k + 0.4));
        2: v = cval;
        default: v = int'($urandom_range(4095)) - 2048;
      endcase
      d[ch*DW +: DW] = v[DW-1:0];
    end
    return d;
  endfunction

  task automatic do_start(input logic [31:0] tw, input logic [10:0] rr, input bit junk);
    @(negedge clk);
    start = 1'b1; tune = tw; ratio = rr;
    in_valid = junk; in_data = 48'({$urandom, $urandom});
    new_cfg(tw, rr);
    @(negedge clk);
    start = 1'b0; in_valid = 1'b0;
    chk(out_valid == 1'b0, "R8", "valid after start", 128'(out_valid), 128'(0));
    chk(out_i == '0 && out_q == '0, "R8", "outputs after start", 128'(out_i ^ out_q), 128'(0));
  endtask

  task automatic feed(input int n, input int mode, input bit gap, input int cval);
    for (int k = 0; k < n; k++) begin
      logic [NCH*DW-1:0] d;
      if (gap && (k % 3 == 1)) begin
        @(negedge clk);
        in_valid = 1'b0; in_data = 48'({$urandom, $urandom});
        tune = $urandom; ratio = 11'($urandom);
      end
      @(negedge clk);
      d = gen(mode, k, cval);
      in_valid = 1'b1; in_data = d;
      model_push(d);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain(input string tag);
    repeat (8) @(negedge clk);
    chk(qi.size() == 0, "R5", {tag, " missing outputs"}, 128'(qi.size()), 128'(0));
    chk(seen == exp_out, "R5", {tag, " output count"}, 128'(seen), 128'(exp_out));
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      seen++;
      last_i = out_i; last_q = out_q;
      if (qi.size() == 0) begin
        chk(1'b0, "R5", "unexpected output", 128'(out_i), 128'(0));
      end else begin
        logic [NCH*OW-1:0] ei, eq;
        ei = qi.pop_front(); eq = qq.pop_front();
        chk(out_i == ei, "R1 R2 R4", "I outputs", 128'(out_i), 128'(ei));
        chk(out_q == eq, "R1 R2 R4", "Q outputs", 128'(out_q), 128'(eq));
      end
      if (same)
        for (int ch = 1; ch < NCH; ch++)
          chk(out_i[ch*OW +: OW] == out_i[OW-1:0] && out_q[ch*OW +: OW] == out_q[OW-1:0],
              "R3", "channel match", 128'({out_i[ch*OW +: OW], out_q[ch*OW +: OW]}),
              128'({out_i[OW-1:0], out_q[OW-1:0]}));
      if (cont && last_cyc >= 0)
        chk(cyc - last_cyc == m_r, "R5", "pulse spacing", 128'(cyc - last_cyc), 128'(m_r));
      last_cyc = cyc;
    end
  end

  task automatic summary;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; in_valid = 1'b0; in_data = '0;
    tune = '0; ratio = 11'd8; cont = 1'b0; same = 1'b0;
    new_cfg(32'd0, 11'd8);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R10", "reset valid", 128'(out_valid), 128'(0));
    chk(out_i == '0 && out_q == '0, "R10", "reset outputs", 128'(out_i | out_q), 128'(0));

    // R1: quarter-rate oscillator on a constant input cancels over each window
    cont = 1'b1;
    do_start(32'h4000_0000, 11'd8, 1'b0);
    feed(64, 2, 1'b0, 1000);
    drain("R1 run");
    chk(last_i == '0 && last_q == '0, "R1", "quarter-rate result", 128'(last_i | last_q), 128'(0));

    // R2 R4: tone with per-channel phase offsets
    do_start(32'h1A2B_3C4D, 11'd8, 1'b0);
    feed(240, 0, 1'b0, 0);
    drain("R4 tone run");

    // R3: identical inputs on every channel
    same = 1'b1;
    do_start(32'h3000_0000, 11'd16, 1'b0);
    feed(320, 1, 1'b0, 0);
    drain("R3 run");
    same = 1'b0;

    // R9: gaps with garbage data and changing control inputs
    cont = 1'b0;
    do_start(32'h0123_4567, 11'd32, 1'b0);
    feed(400, 3, 1'b1, 0);
    drain("R9 gap run");

    // R6 R7 R8: sample during start discarded, ratio below range, inputs changed afterwards
    cont = 1'b1;
    do_start(32'h2222_1111, 11'd3, 1'b1);
    tune = 32'h7777_0000; ratio = 11'd40;
    feed(160, 0, 1'b0, 0);
    drain("R7 R8 run");

    // R6 R4: ratio above range, full-scale negative input
    do_start(32'h0, 11'd1500, 1'b0);
    feed(4096, 2, 1'b0, -2048);
    drain("R6 run");
    for (int ch = 0; ch < NCH; ch++) begin
      chk(last_i[ch*OW +: OW] == 24'(-8384512), "R6", "full-scale I",
          128'(last_i[ch*OW +: OW]), 128'(24'(-8384512)));
      chk(last_q[ch*OW +: OW] == '0, "R6", "full-scale Q",
          128'(last_q[ch*OW +: OW]), 128'(0));
    end

    summary();
    $finish;
  end
endmodule